// File: doc/BRIEF.md
# Bit-Reversed Address Generator

This block forms the write effective address and the updated pointer value for one indirect access of a data address unit. It is meant for radix-2 FFT data reordering. The block looks at the selected pointer, the pointer-select field, the addressing mode, the access direction and the data size. When bit-reversed stepping is qualified, it adds a word-granular modifier to the pointer. In that addition the carries travel from the most significant bit toward the least significant bit. The effect is that a linear walk through a buffer of 2^N words visits its entries in bit-reversed order.

When bit-reversed stepping is not qualified, the block produces the ordinary indirect address and pointer update for the mode. The modifier register carries both the enable flag and the modifier. Results are registered, so they appear one clock after the request. A separate output tells a downstream modulo-correction stage whether it may act on this access. Bit-reversed stepping always overrides that stage.

Top module: `brev_agen`

## Requirements
- R1: Bit-reversed stepping is active only when all of the following hold together: the pointer-select field is not 15 (15 selects the stack pointer), bit 15 of the modifier register is 1, the mode is pre-increment (code 3) or post-increment (code 1), the access is a write (`acc_wr`=1) and the access is word-sized (`acc_byte`=0). `brev_act` reports this.
- R2: When active, the new pointer is `{S,0}`. S is the 15-bit reverse-carry sum of `ptr_in[15:1]` and `xmod_reg[14:0]`, with carries moving from bit 14 toward bit 0. The LSb of `ptr_in` is ignored, and bit 0 of every bit-reversed address is 0. Starting at a 16-word aligned base with modifier 8, successive post-increment steps visit the word offsets 0,8,4,12,2,10,6,14,1,9,5,13,3,11,7,15 and then return to 0.
- R3: When active, the mode's own ±1 or ±2 step is not added.
- R4: When active, the new pointer is written back (`ptr_we`=1) in both modes. In pre-increment mode `ea_out` equals the new pointer. In post-increment mode `ea_out` is the old pointer with bit 0 cleared.
- R5: When not active, the post-increment and post-decrement modes (codes 1 and 2) give `ea_out`=`ptr_in`. The pre-increment and pre-decrement modes (codes 3 and 4) give `ea_out`= the new pointer. The new pointer is `ptr_in` ±2 for words and ±1 for bytes, and `ptr_we`=1.
- R6: Plain indirect mode (code 0, and also the unused codes 6 and 7) gives `ea_out`=`ptr_in`. Offset mode (code 5) gives `ea_out`=`ptr_in`+`off_in`. Both leave `ptr_next`=`ptr_in` with `ptr_we`=0.
- R7: `mod_en` follows `mod_req` for a valid request, except that it is 0 whenever bit-reversed stepping is active.
- R8: A synchronous active-high reset clears all outputs to 0.
- R9: A cycle with `req_vld`=0 gives `out_vld`=0, `ptr_we`=0, `brev_act`=0 and `mod_en`=0 on the next cycle.
- R10: All outputs reflect the request sampled on the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Access request present this cycle |
| ptr_in | input | 16 | Current byte address held in the selected pointer |
| ptr_sel | input | 4 | Number of the selected pointer register |
| xmod_reg | input | 16 | Bit 15 is the enable flag; bits 14:0 are the word modifier |
| amode | input | 3 | Addressing mode code |
| off_in | input | 16 | Byte offset used by offset mode |
| acc_wr | input | 1 | 1 for a write access |
| acc_byte | input | 1 | 1 for a byte-sized access |
| mod_req | input | 1 | Modulo correction requested for this access |
| out_vld | output | 1 | Registered results are valid |
| ea_out | output | 16 | Effective byte address |
| ptr_next | output | 16 | Updated pointer value |
| ptr_we | output | 1 | Pointer write-back strobe |
| brev_act | output | 1 | Bit-reversed stepping was applied |
| mod_en | output | 1 | Modulo correction allowed |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 15-bit word modifier and a 4-bit pointer select. With these values the stack-pointer code 15 can be driven, and so can a full carry-out wrap of the reverse-carry sum. Full bit-reversed walks over 16-word and 32-word buffers are run; the bench computes the expected order on its own by reversing the index. A vector table then covers each enable condition failing on its own, the byte and read cases, and the odd-pointer case, followed by directed checks of the modulo override and the offset mode.

// File: rtl/brev_agen_pkg.sv
package brev_agen_pkg;

    localparam int DEF_ADDR_W = 16;
    localparam int DEF_SEL_W  = 4;

    typedef enum logic [2:0] {
        AM_IND     = 3'd0,
        AM_POSTINC = 3'd1,
        AM_POSTDEC = 3'd2,
        AM_PREINC  = 3'd3,
        AM_PREDEC  = 3'd4,
        AM_OFFSET  = 3'd5
    } amode_e;

    typedef struct packed {
        logic vld;
        logic we;
        logic brev;
        logic mod_ok;
        logic pre;
    } flags_t;

    function automatic logic is_inc_mode(input logic [2:0] m);
        return (m == AM_POSTINC) || (m == AM_PREINC);
    endfunction

    function automatic logic is_pre_mode(input logic [2:0] m);
        return (m == AM_PREINC) || (m == AM_PREDEC);
    endfunction

endpackage

// File: rtl/brev_qual.sv
module brev_qual
    import brev_agen_pkg::*;
#(
    parameter int SEL_W = DEF_SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             en_flag,
    input  logic [2:0]       mode,
    input  logic             wr,
    input  logic             byte_acc,
    output logic             active
);
    localparam logic [SEL_W-1:0] STACK_SEL = {SEL_W{1'b1}};

    logic not_stack;
    logic size_dir_ok;

    always_comb begin
        not_stack   = (sel != STACK_SEL);
        size_dir_ok = wr && !byte_acc;
        active      = not_stack && en_flag && is_inc_mode(mode) && size_dir_ok;
    end
endmodule

// File: rtl/brev_rcadd.sv
module brev_rcadd #(
    parameter int W = 15
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    logic [W:0] cy;

    assign cy[W] = 1'b0;

    genvar i;
    generate
        for (i = W - 1; i >= 0; i--) begin : g_bit
            assign s[i]  = a[i] ^ b[i] ^ cy[i+1];
            assign cy[i] = (a[i] & b[i]) | (a[i] & cy[i+1]) | (b[i] & cy[i+1]);
        end
    endgenerate

    function automatic logic [W-1:0] flip(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int k = 0; k < W; k++) r[k] = v[W-1-k];
        return r;
    endfunction

    always_comb begin
        if (!$isunknown({a, b})) begin
            AST_RCADD_MATCH: assert (s == flip(flip(a) + flip(b))); // R2
        end
    end
endmodule

// File: rtl/brev_lin.sv
module brev_lin
    import brev_agen_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] off,
    input  logic [2:0]        mode,
    input  logic              byte_acc,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] nxt,
    output logic              we
);
    localparam logic [ADDR_W-1:0] STEP_B = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(2);

    logic [ADDR_W-1:0] step;

    always_comb begin
        step = byte_acc ? STEP_B : STEP_W;
        ea   = ptr;
        nxt  = ptr;
        we   = 1'b0;
        case (mode)
            AM_POSTINC: begin nxt = ptr + step; we = 1'b1; end
            AM_POSTDEC: begin nxt = ptr - step; we = 1'b1; end
            AM_PREINC:  begin nxt = ptr + step; ea = nxt; we = 1'b1; end
            AM_PREDEC:  begin nxt = ptr - step; ea = nxt; we = 1'b1; end
            AM_OFFSET:  ea = ptr + off;
            default:    ;
        endcase
    end
endmodule

// File: rtl/brev_agen.sv
module brev_agen
    import brev_agen_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int SEL_W  = DEF_SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic [ADDR_W-1:0] ptr_in,
    input  logic [SEL_W-1:0]  ptr_sel,
    input  logic [ADDR_W-1:0] xmod_reg,
    input  logic [2:0]        amode,
    input  logic [ADDR_W-1:0] off_in,
    input  logic              acc_wr,
    input  logic              acc_byte,
    input  logic              mod_req,
    output logic              out_vld,
    output logic [ADDR_W-1:0] ea_out,
    output logic [ADDR_W-1:0] ptr_next,
    output logic              ptr_we,
    output logic              brev_act,
    output logic              mod_en
);
    localparam int WA_W = ADDR_W - 1;

    logic              brev_on;
    logic [WA_W-1:0]   word_sum;
    logic [ADDR_W-1:0] lin_ea, lin_nxt;
    logic              lin_we;
    logic [ADDR_W-1:0] br_nxt, br_ea;
    logic [ADDR_W-1:0] ea_d, nxt_d;
    flags_t            fl_d, fl_q;
    logic [ADDR_W-1:0] ea_q, nxt_q;

    brev_qual #(.SEL_W(SEL_W)) u_qual (
        .sel      (ptr_sel),
        .en_flag  (xmod_reg[ADDR_W-1]),
        .mode     (amode),
        .wr       (acc_wr),
        .byte_acc (acc_byte),
        .active   (brev_on)
    );

    brev_rcadd #(.W(WA_W)) u_add (
        .a (ptr_in[ADDR_W-1:1]),
        .b (xmod_reg[WA_W-1:0]),
        .s (word_sum)
    );

    brev_lin #(.ADDR_W(ADDR_W)) u_lin (
        .ptr      (ptr_in),
        .off      (off_in),
        .mode     (amode),
        .byte_acc (acc_byte),
        .ea       (lin_ea),
        .nxt      (lin_nxt),
        .we       (lin_we)
    );

    always_comb begin
        br_nxt = {word_sum, 1'b0};
        br_ea  = is_pre_mode(amode) ? br_nxt : {ptr_in[ADDR_W-1:1], 1'b0};
        ea_d   = brev_on ? br_ea  : lin_ea;
        nxt_d  = brev_on ? br_nxt : lin_nxt;
        fl_d.vld    = req_vld;
        fl_d.we     = req_vld && (brev_on || lin_we);
        fl_d.brev   = req_vld && brev_on;
        fl_d.mod_ok = req_vld && mod_req && !brev_on;
        fl_d.pre    = is_pre_mode(amode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q  <= '0;
            ea_q  <= '0;
            nxt_q <= '0;
        end else begin
            fl_q <= fl_d;
            if (req_vld) begin
                ea_q  <= ea_d;
                nxt_q <= nxt_d;
            end
        end
    end

    assign out_vld  = fl_q.vld;
    assign ea_out   = ea_q;
    assign ptr_next = nxt_q;
    assign ptr_we   = fl_q.we;
    assign brev_act = fl_q.brev;
    assign mod_en   = fl_q.mod_ok;

    AST_BREV_EA_EVEN: assert property (@(posedge clk) disable iff (rst) brev_act |-> (ea_out[0] == 1'b0 && ptr_next[0] == 1'b0)); // R2
    AST_BREV_WB: assert property (@(posedge clk) disable iff (rst) brev_act |-> ptr_we); // R4
    AST_BREV_PRE_EA: assert property (@(posedge clk) disable iff (rst) (brev_act && fl_q.pre) |-> ea_out == ptr_next); // R4
    AST_MOD_BLOCKED: assert property (@(posedge clk) disable iff (rst) brev_act |-> !mod_en); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !out_vld |-> (!ptr_we && !brev_act && !mod_en)); // R9
    AST_STACK_NEVER: assert property (@(posedge clk) disable iff (rst) (req_vld && ptr_sel == {SEL_W{1'b1}}) |=> !brev_act); // R1
endmodule

// File: tb/brev_agen_tb_top.sv
module brev_agen_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_vld;
    logic [15:0] ptr_in;
    logic [3:0]  ptr_sel;
    logic [15:0] xmod_reg;
    logic [2:0]  amode;
    logic [15:0] off_in;
    logic        acc_wr, acc_byte, mod_req;
    logic        out_vld, ptr_we, brev_act, mod_en;
    logic [15:0] ea_out, ptr_next;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    brev_agen dut_i (
        .clk(clk), .rst(rst), .req_vld(req_vld), .ptr_in(ptr_in), .ptr_sel(ptr_sel),
        .xmod_reg(xmod_reg), .amode(amode), .off_in(off_in), .acc_wr(acc_wr),
        .acc_byte(acc_byte), .mod_req(mod_req), .out_vld(out_vld), .ea_out(ea_out),
        .ptr_next(ptr_next), .ptr_we(ptr_we), .brev_act(brev_act), .mod_en(mod_en)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic [3:0]  sel;
        logic [15:0] xb;
        logic [15:0] ptr;
        logic        wr;
        logic        byt;
        logic [15:0] ea;
        logic [15:0] nx;
        logic        we;
        logic        br;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{3'd3, 4'd2,  16'h8008, 16'h0100, 1'b1, 1'b0, 16'h0110, 16'h0110, 1'b1, 1'b1},
        '{3'd1, 4'd2,  16'h8008, 16'h0110, 1'b1, 1'b0, 16'h0110, 16'h0108, 1'b1, 1'b1},
        '{3'd1, 4'd15, 16'h8008, 16'h0100, 1'b1, 1'b0, 16'h0100, 16'h0102, 1'b1, 1'b0},
        '{3'd3, 4'd2,  16'h0008, 16'h0100, 1'b1, 1'b0, 16'h0102, 16'h0102, 1'b1, 1'b0},
        '{3'd1, 4'd2,  16'h8008, 16'h0100, 1'b0, 1'b0, 16'h0100, 16'h0102, 1'b1, 1'b0},
        '{3'd1, 4'd2,  16'h8008, 16'h0100, 1'b1, 1'b1, 16'h0100, 16'h0101, 1'b1, 1'b0},
        '{3'd2, 4'd2,  16'h8008, 16'h0100, 1'b1, 1'b0, 16'h0100, 16'h00FE, 1'b1, 1'b0},
        '{3'd4, 4'd2,  16'h8008, 16'h0100, 1'b1, 1'b0, 16'h00FE, 16'h00FE, 1'b1, 1'b0},
        '{3'd0, 4'd2,  16'h8008, 16'h0100, 1'b1, 1'b0, 16'h0100, 16'h0100, 1'b0, 1'b0},
        '{3'd3, 4'd2,  16'h8008, 16'h0101, 1'b1, 1'b0, 16'h0110, 16'h0110, 1'b1, 1'b1},
        '{3'd1, 4'd2,  16'h8008, 16'h001E, 1'b1, 1'b0, 16'h001E, 16'h0000, 1'b1, 1'b1},
        '{3'd6, 4'd2,  16'h8008, 16'h0100, 1'b1, 1'b0, 16'h0100, 16'h0100, 1'b0, 1'b0}
    };

    localparam logic [3:0] SEQ16 [16] = '{4'd0, 4'd8, 4'd4, 4'd12, 4'd2, 4'd10, 4'd6, 4'd14,
                                          4'd1, 4'd9, 4'd5, 4'd13, 4'd3, 4'd11, 4'd7, 4'd15};

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [2:0] m, input logic [3:0] s, input logic [15:0] xb,
                         input logic [15:0] p, input logic w, input logic b,
                         input logic [15:0] o, input logic mr);
        @(negedge clk);
        req_vld = 1'b1; amode = m; ptr_sel = s; xmod_reg = xb; ptr_in = p;
        acc_wr = w; acc_byte = b; off_in = o; mod_req = mr;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] p;
        rst = 1'b1; req_vld = 1'b1; ptr_in = 16'h1234; ptr_sel = 4'd1; xmod_reg = 16'h8008;
        amode = 3'd3; off_in = 16'h0; acc_wr = 1'b1; acc_byte = 1'b0; mod_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 reset vld",  {15'd0, out_vld}, 16'd0);
        chk("R8 reset ea",   ea_out, 16'd0);
        chk("R8 reset next", ptr_next, 16'd0);
        chk("R8 reset flags", {12'd0, ptr_we, brev_act, mod_en, 1'b0}, 16'd0);
        rst = 1'b0; req_vld = 1'b0;
        @(negedge clk);
        chk("R9 idle", {12'd0, out_vld, ptr_we, brev_act, mod_en}, 16'd0);

        // R2 walk of a 16-word buffer with the table order
        p = 16'h0200;
        for (int k = 0; k < 17; k++) begin
            drive(3'd1, 4'd3, 16'h8008, p, 1'b1, 1'b0, 16'h0, 1'b0);
            chk("R2 seq16 ea", ea_out, 16'h0200 + {11'd0, SEQ16[k % 16], 1'b0});
            chk("R10 vld", {15'd0, out_vld}, 16'd1);
            p = ptr_next;
        end

        // R2 walk of a 32-word buffer, order from index reversal
        p = 16'h0400;
        for (int k = 0; k < 32; k++) begin
            logic [4:0] kk, rv;
            kk = 5'(k);
            for (int j = 0; j < 5; j++) rv[j] = kk[4 - j];
            drive(3'd1, 4'd5, 16'h8010, p, 1'b1, 1'b0, 16'h0, 1'b0);
            chk("R2 seq32 ea", ea_out, 16'h0400 + {10'd0, rv, 1'b0});
            p = ptr_next;
        end

        // R1 R3 R4 R5 R6 table
        for (int i = 0; i < NV; i++) begin
            drive(VT[i].mode, VT[i].sel, VT[i].xb, VT[i].ptr, VT[i].wr, VT[i].byt, 16'h0, 1'b0);
            chk($sformatf("R4/R5/R6 ea v%0d", i), ea_out, VT[i].ea);
            chk($sformatf("R3 next v%0d", i), ptr_next, VT[i].nx);
            chk($sformatf("R6 we v%0d", i), {15'd0, ptr_we}, {15'd0, VT[i].we});
            chk($sformatf("R1 brev v%0d", i), {15'd0, brev_act}, {15'd0, VT[i].br});
        end

        // R6 offset mode
        drive(3'd5, 4'd2, 16'h8008, 16'h0100, 1'b1, 1'b0, 16'h0034, 1'b0);
        chk("R6 offset ea", ea_out, 16'h0134);
        chk("R6 offset nx", ptr_next, 16'h0100);
        chk("R6 offset we", {15'd0, ptr_we}, 16'd0);

        // R7 modulo override
        drive(3'd1, 4'd2, 16'h8008, 16'h0100, 1'b1, 1'b0, 16'h0, 1'b1);
        chk("R7 mod blocked", {15'd0, mod_en}, 16'd0);
        drive(3'd1, 4'd15, 16'h8008, 16'h0100, 1'b1, 1'b0, 16'h0, 1'b1);
        chk("R7 mod pass", {15'd0, mod_en}, 16'd1);

        // R9 idle after activity
        @(negedge clk);
        chk("R9 idle after", {12'd0, out_vld, ptr_we, brev_act, mod_en}, 16'd0);

        // R8 reset mid-run
        @(negedge clk);
        req_vld = 1'b1; rst = 1'b1;
        @(negedge clk);
        chk("R8 mid reset", {12'd0, out_vld, ptr_we, brev_act, mod_en}, 16'd0);
        chk("R8 mid reset ea", ea_out, 16'd0);
        rst = 1'b0; req_vld = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule